// File: doc/BRIEF.md
# Host-Fed FIFO to DMA Bridge

This block lets a 16-bit host stream words into a small FIFO. A single DMA channel then moves those words to a destination memory through a word-write port. On the host side there are three registers: a control byte, a length register and a data port. On the channel side there are registers for the source address, the destination address, the transfer count, the channel control and a global operation enable.

The channel drains the FIFO in bursts of four words, and only when three things hold: the FIFO holds a whole number of four-word groups, the channel is in the expected mode, and the global enable is set. Each moved word advances the destination address and counts down two counters, the host length and the channel count. Each counter ends its own side of the transfer.

The destination port is valid/ready. `dst_valid` rises only during a burst. Once raised, it stays high and `dst_addr`/`dst_data` stay unchanged until `dst_ready` is seen high at a clock edge. Every such edge moves exactly one word. The destination may stall for any number of cycles.

Top module: `stream_dma_bridge`

## Requirements
- R1: A write to the host length register (host select 1) stores the data with its two lowest bits forced to zero.
- R2: A write to the FIFO data port (host select 2) is ignored unless the transfer enable bit (bit 2 of the host control byte) is set.
- R3: The FULL flag (bit 7 of `host_ctl_rd`) is 1 exactly while the FIFO holds 8 words, and it returns to 0 once the channel has drained words.
- R4: A burst starts only when the FIFO level is a nonzero multiple of four, the channel control bits [1:0] equal 01, bit 0 of the operation register (channel select 4) is 1 and the channel count is nonzero. Each burst moves at most four words.
- R5: Each moved word adds 2 to the destination address (channel select 1) and subtracts 1 from both the channel count and the host length. Moving stops as soon as the channel count is zero.
- R6: When the host length counts down to zero, the transfer enable bit clears by itself.
- R7: When the channel count counts down to zero, bit 1 of the channel control register (channel select 3) is set. This makes the mode bits read 11, so no further drains start.
- R8: The channel count register (channel select 2) keeps only the low 24 bits of the written value.
- R9: A write to the host control byte (host select 0) changes only the transfer enable bit (bit 2) and the RV bit (bit 0). FULL keeps its value.
- R10: Host data writes that arrive while FULL is set are dropped.
- R11: Words leave on the destination port in the order they were accepted, one per valid/ready handshake. Valid, address and data are held while ready is low.
- R12: Words that are already waiting start to drain when the channel enables are set after the fourth word has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register: 0 control, 1 length, 2 FIFO data |
| host_wdata | input | 16 | Host write data |
| host_ctl_rd | output | 8 | Host control byte: bit 7 FULL, bit 2 enable, bit 0 RV |
| host_len | output | 16 | Remaining host length in words |
| cfg_wr_en | input | 1 | Channel register write strobe |
| cfg_sel | input | 3 | Channel register: 0 source, 1 destination, 2 count, 3 control, 4 operation |
| cfg_wdata | input | 32 | Channel write data |
| chan_src | output | 32 | Source address register |
| chan_cnt | output | 24 | Remaining channel count |
| chan_ctl | output | 16 | Channel control register |
| dst_valid | output | 1 | Word available on the destination port |
| dst_ready | input | 1 | Destination accepts the word |
| dst_addr | output | 32 | Destination byte address |
| dst_data | output | 16 | Destination word |

## Verification
A sweep runs transfers of 4 to 20 words. The channel count is either equal to the word count or four larger, so the test can tell apart the channel count ending the transfer and the host length ending it. Each transfer runs under four destination ready patterns: always ready, alternating, one cycle in three, and two-low-two-high. These show whether stalls lose, repeat or reorder words. Directed cases send groups of three words, disabled modes, a late enable and a filled FIFO with an extra word. These separate the burst gating, the dropping of words and the preservation of FULL. A channel count of two against a four-word group shows that the burst stops part-way.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic [1:0] {
    HOST_CTL  = 2'd0,
    HOST_LEN  = 2'd1,
    HOST_FIFO = 2'd2
  } host_sel_e;

  typedef enum logic [2:0] {
    CH_SRC = 3'd0,
    CH_DST = 3'd1,
    CH_CNT = 3'd2,
    CH_CTL = 3'd3,
    CH_OPR = 3'd4
  } chan_sel_e;

  typedef enum logic {
    DR_IDLE  = 1'b0,
    DR_BURST = 1'b1
  } drain_st_e;

  localparam int CTL_RV_BIT   = 0;
  localparam int CTL_EN_BIT   = 2;
  localparam int CTL_FULL_BIT = 7;
  localparam int CH_TE_BIT    = 1;
endpackage

// File: rtl/sdb_fifo.sv
module sdb_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  assign head = mem[rd_ptr];
  assign full = (level == LW'(DEPTH));

  // R10
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R11
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level != '0);
endmodule

// File: rtl/sdb_host_regs.sv
module sdb_host_regs
  import sdb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          fifo_full,
  input  logic          len_dec,
  output logic          xfer_en,
  output logic          rv,
  output logic [DW-1:0] len,
  output logic          push
);
  logic ctl_wr, len_wr, dat_wr;

  assign ctl_wr = wr_en && (sel == HOST_CTL);
  assign len_wr = wr_en && (sel == HOST_LEN);
  assign dat_wr = wr_en && (sel == HOST_FIFO);
  assign push   = dat_wr && xfer_en && !fifo_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_en <= 1'b0;
      rv      <= 1'b0;
      len     <= '0;
    end else begin
      if (len_dec && len != '0) len <= len - DW'(1);
      if (len_dec && len == DW'(1)) xfer_en <= 1'b0;
      if (ctl_wr) begin
        xfer_en <= wdata[CTL_EN_BIT];
        rv      <= wdata[CTL_RV_BIT];
      end
      if (len_wr) len <= {wdata[DW-1:2], 2'b00};
    end
  end

  // R1
  len_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr |=> len[1:0] == 2'b00);

  // R6
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_en) |-> ($past(ctl_wr) || len == '0));

  // R9
  rv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(rv));
endmodule

// File: rtl/sdb_dma_chan.sv
module sdb_dma_chan
  import sdb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 24,
  parameter int CTL_W = 16,
  parameter int LW    = 4,
  parameter int BURST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic [LW-1:0]    fifo_level,
  input  logic             dst_ready,
  output logic             dst_valid,
  output logic [AW-1:0]    dst_addr,
  output logic             pop,
  output logic             len_dec,
  output logic [AW-1:0]    chan_src,
  output logic [CNT_W-1:0] chan_cnt,
  output logic [CTL_W-1:0] chan_ctl
);
  localparam int BW = (BURST > 1) ? $clog2(BURST) : 1;

  drain_st_e      state;
  logic [BW-1:0]  beat;
  logic           opr_en;
  logic           hs, level_ok, start_ok;

  assign hs       = dst_valid && dst_ready;
  assign pop      = hs;
  assign len_dec  = hs;
  assign level_ok = (fifo_level != '0) && ((fifo_level % LW'(BURST)) == '0);
  assign start_ok = (state == DR_IDLE) && level_ok && (chan_ctl[1:0] == 2'b01)
                    && opr_en && (chan_cnt != '0);
  assign dst_valid = (state == DR_BURST) && (chan_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= DR_IDLE;
      beat  <= '0;
    end else begin
      case (state)
        DR_IDLE: begin
          beat <= '0;
          if (start_ok) state <= DR_BURST;
        end
        default: begin
          if (chan_cnt == '0) begin
            state <= DR_IDLE;
          end else if (hs) begin
            beat <= beat + BW'(1);
            if (beat == BW'(BURST-1) || chan_cnt == CNT_W'(1)) state <= DR_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_src <= '0;
      dst_addr <= '0;
      chan_cnt <= '0;
      chan_ctl <= '0;
      opr_en   <= 1'b0;
    end else begin
      if (hs) begin
        dst_addr <= dst_addr + AW'(2);
        chan_cnt <= chan_cnt - CNT_W'(1);
        if (chan_cnt == CNT_W'(1)) chan_ctl[CH_TE_BIT] <= 1'b1;
      end
      if (cfg_wr) begin
        case (cfg_sel)
          CH_SRC:  chan_src <= cfg_wdata;
          CH_DST:  dst_addr <= cfg_wdata;
          CH_CNT:  chan_cnt <= cfg_wdata[CNT_W-1:0];
          CH_CTL:  chan_ctl <= cfg_wdata[CTL_W-1:0];
          CH_OPR:  opr_en   <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // R5
  dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !cfg_wr |=> dst_addr == $past(dst_addr) + AW'(2));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !cfg_wr |=> chan_cnt == $past(chan_cnt) - CNT_W'(1));

  // R7
  te_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && chan_cnt == CNT_W'(1) && !cfg_wr |=> chan_ctl[CH_TE_BIT]);

  // R4
  start_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dst_valid) |-> fifo_level >= LW'(BURST));

  // R11
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready && !cfg_wr |=> dst_valid && $stable(dst_addr));
endmodule

// File: rtl/stream_dma_bridge.sv
module stream_dma_bridge
  import sdb_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 32,
  parameter int CNT_W = 24,
  parameter int CTL_W = 16,
  parameter int DEPTH = 8,
  parameter int BURST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr_en,
  input  logic [1:0]       host_sel,
  input  logic [DW-1:0]    host_wdata,
  output logic [7:0]       host_ctl_rd,
  output logic [DW-1:0]    host_len,
  input  logic             cfg_wr_en,
  input  logic [2:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  output logic [AW-1:0]    chan_src,
  output logic [CNT_W-1:0] chan_cnt,
  output logic [CTL_W-1:0] chan_ctl,
  output logic             dst_valid,
  input  logic             dst_ready,
  output logic [AW-1:0]    dst_addr,
  output logic [DW-1:0]    dst_data
);
  localparam int LW = $clog2(DEPTH+1);

  logic          push, pop, len_dec, fifo_full, xfer_en, rv;
  logic [LW-1:0] level;

  sdb_host_regs #(.DW(DW)) u_host (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .sel(host_sel),
    .wdata(host_wdata), .fifo_full(fifo_full), .len_dec(len_dec),
    .xfer_en(xfer_en), .rv(rv), .len(host_len), .push(push)
  );

  sdb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(host_wdata),
    .pop(pop), .head(dst_data), .level(level), .full(fifo_full)
  );

  sdb_dma_chan #(.AW(AW), .CNT_W(CNT_W), .CTL_W(CTL_W), .LW(LW), .BURST(BURST)) u_chan (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fifo_level(level), .dst_ready(dst_ready),
    .dst_valid(dst_valid), .dst_addr(dst_addr), .pop(pop), .len_dec(len_dec),
    .chan_src(chan_src), .chan_cnt(chan_cnt), .chan_ctl(chan_ctl)
  );

  always_comb begin
    host_ctl_rd = '0;
    host_ctl_rd[CTL_FULL_BIT] = fifo_full;
    host_ctl_rd[CTL_EN_BIT]   = xfer_en;
    host_ctl_rd[CTL_RV_BIT]   = rv;
  end

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready && !cfg_wr_en |=> $stable(dst_data));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && pop && !push |=> !host_ctl_rd[CTL_FULL_BIT]);
endmodule

// File: tb/tb_stream_dma_bridge.sv
module tb_stream_dma_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [15:0] host_wdata = '0;
  logic [7:0]  host_ctl_rd;
  logic [15:0] host_len;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] chan_src;
  logic [23:0] chan_cnt;
  logic [15:0] chan_ctl;
  logic        dst_valid;
  logic        dst_ready = 1'b0;
  logic [31:0] dst_addr;
  logic [15:0] dst_data;

  stream_dma_bridge dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int beats = 0;
  int rcnt = 0;
  int rmode = 0;
  logic [31:0] got_addr [64];
  logic [15:0] got_data [64];

  always @(posedge clk) begin
    if (rst_n && dst_valid && dst_ready) begin
      got_addr[beats % 64] <= dst_addr;
      got_data[beats % 64] <= dst_data;
      beats <= beats + 1;
    end
  end

  always @(negedge clk) begin
    rcnt <= rcnt + 1;
    case (rmode)
      0: dst_ready <= 1'b1;
      1: dst_ready <= rcnt[0];
      2: dst_ready <= (rcnt % 3 == 0);
      default: dst_ready <= rcnt[1];
    endcase
  end

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic hw(logic [1:0] s, logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic cw(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; host_wr_en = 1'b0; cfg_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_words(int n, logic [15:0] first);
    for (int i = 0; i < n; i++) begin
      while (host_ctl_rd[7]) @(negedge clk);
      hw(2'd2, first + 16'(i));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int base;
    rmode = 0;
    do_reset();
    chk("reset host_ctl_rd", {24'h0, host_ctl_rd}, 32'h0);
    chk("reset host_len", {16'h0, host_len}, 32'h0);
    chk("reset dst_valid", {31'h0, dst_valid}, 32'h0);
    chk("reset chan_cnt", {8'h0, chan_cnt}, 32'h0);
    chk("reset chan_ctl", {16'h0, chan_ctl}, 32'h0);

    // R1 length masking
    hw(2'd1, 16'h0007);
    chk("R1 len 7", {16'h0, host_len}, 32'h4);
    hw(2'd1, 16'hFFFF);
    chk("R1 len FFFF", {16'h0, host_len}, 32'hFFFC);

    // R2 data ignored with enable clear
    base = beats;
    push_words(4, 16'h5550);
    cw(3'd1, 32'h0000_0400); cw(3'd2, 32'd16); cw(3'd3, 32'h1); cw(3'd4, 32'h1);
    repeat (20) @(negedge clk);
    chk("R2 no words while disabled", beats - base, 0);

    // R3 R9 R10 R8 R12 fill with channel disabled
    do_reset();
    hw(2'd1, 16'd16);
    hw(2'd0, 16'h0004);
    for (int i = 0; i < 9; i++) hw(2'd2, 16'hA000 + 16'(i));
    chk("R3 full set at 8", {31'h0, host_ctl_rd[7]}, 32'h1);
    hw(2'd0, 16'h0005);
    chk("R9 ctl write keeps full, sets rv", {24'h0, host_ctl_rd}, 32'h85);
    hw(2'd0, 16'h0004);
    chk("R9 rv cleared, full kept", {24'h0, host_ctl_rd}, 32'h84);
    cw(3'd1, 32'h0000_0100);
    cw(3'd2, 32'hFF00_0010);
    chk("R8 count low 24 bits", {8'h0, chan_cnt}, 32'h10);
    cw(3'd0, 32'h1234_5678);
    chk("src register", chan_src, 32'h1234_5678);
    base = beats;
    cw(3'd3, 32'h1); cw(3'd4, 32'h1);
    repeat (30) @(negedge clk);
    chk("R12 late enable drains 8", beats - base, 8);
    chk("R10 last word is eighth", {16'h0, got_data[(base + 7) % 64]}, 32'hA007);
    chk("R3 full cleared", {31'h0, host_ctl_rd[7]}, 32'h0);
    chk("R5 len after 8", {16'h0, host_len}, 32'd8);
    chk("R5 cnt after 8", {8'h0, chan_cnt}, 32'd8);
    chk("R5 dst after 8", dst_addr, 32'h110);

    // R4 partial group waits
    push_words(3, 16'hB000);
    repeat (20) @(negedge clk);
    chk("R4 three words wait", beats - base, 8);
    push_words(1, 16'hB003);
    repeat (20) @(negedge clk);
    chk("R4 fourth word starts burst", beats - base, 12);
    chk("R11 data order", {16'h0, got_data[(base + 11) % 64]}, 32'hB003);

    // R6 R7 both counters end together
    push_words(4, 16'hC000);
    repeat (20) @(negedge clk);
    chk("R6 enable cleared at len 0", {24'h0, host_ctl_rd}, 32'h0);
    chk("R7 end flag set", {16'h0, chan_ctl}, 32'h3);
    chk("R5 total moved", beats - base, 16);

    // R5 count stops mid-burst
    do_reset();
    cw(3'd1, 32'h0000_0800); cw(3'd2, 32'd2); cw(3'd3, 32'h1); cw(3'd4, 32'h1);
    hw(2'd1, 16'd8); hw(2'd0, 16'h0004);
    base = beats;
    push_words(4, 16'hD000);
    repeat (20) @(negedge clk);
    chk("R5 stop at count zero", beats - base, 2);
    chk("R7 end flag mid-burst", {16'h0, chan_ctl}, 32'h3);
    chk("R5 len after 2", {16'h0, host_len}, 32'd6);
    chk("R6 enable still set", {24'h0, host_ctl_rd}, 32'h4);

    // R4 mode and global enable gating, R12 later match
    do_reset();
    cw(3'd1, 32'h0000_0C00); cw(3'd2, 32'd8); cw(3'd3, 32'h1); cw(3'd4, 32'h0);
    hw(2'd1, 16'd8); hw(2'd0, 16'h0004);
    base = beats;
    push_words(4, 16'hE000);
    repeat (20) @(negedge clk);
    chk("R4 global enable off", beats - base, 0);
    cw(3'd3, 32'h3); cw(3'd4, 32'h1);
    repeat (20) @(negedge clk);
    chk("R4 mode 11 blocks", beats - base, 0);
    cw(3'd3, 32'h1);
    repeat (20) @(negedge clk);
    chk("R12 drain on mode match", beats - base, 4);

    // Sweep: length, count slack and ready pattern
    for (int n = 4; n <= 20; n += 4) begin
      for (int m = 0; m < 4; m++) begin
        for (int extra = 0; extra <= 4; extra += 4) begin
          int errs;
          logic [15:0] first;
          first = 16'h1000 + 16'(n * 16);
          do_reset();
          rmode = m;
          cw(3'd1, 32'h0000_2000); cw(3'd2, 32'(n + extra));
          cw(3'd3, 32'h1); cw(3'd4, 32'h1);
          hw(2'd1, 16'(n)); hw(2'd0, 16'h0004);
          base = beats;
          push_words(n, first);
          repeat (100) @(negedge clk);
          chk($sformatf("R4 R5 beats n=%0d m=%0d", n, m), beats - base, n);
          errs = 0;
          for (int i = 0; i < n; i++) begin
            if (got_addr[(base + i) % 64] !== 32'h2000 + 32'(2 * i)) errs++;
            if (got_data[(base + i) % 64] !== first + 16'(i)) errs++;
          end
          chk($sformatf("R11 order n=%0d m=%0d", n, m), errs, 0);
          chk("R5 cnt left", {8'h0, chan_cnt}, 32'(extra));
          chk("R5 dst end", dst_addr, 32'h2000 + 32'(2 * n));
          chk("R6 R3 host ctl idle", {24'h0, host_ctl_rd}, 32'h0);
          chk("R7 end flag", {16'h0, chan_ctl}, (extra == 0) ? 32'h3 : 32'h1);
          rmode = 0;
        end
      end
    end

    summary();
    $finish;
  end
endmodule